// File: doc/BRIEF.md
# Event Totalizer with Mapped Control Channel

The block counts events on a single main input and holds a 32-bit running total. The main input only ever adds to the total. A second control signal, the mapped source, is chosen by a 4-bit selector from a 16-bit bank. The lower eight bits of the bank are debounced input channels and the upper eight are setpoint detection flags. A mode field lets the mapped source gate the main input, add to the total or subtract from it. A separate option lets a rising edge on the mapped source take the snapshot of the total in place of the scan-start pulse.

Each snapshot is read out as 16-bit sample words, one word per clock cycle (one sample slot). There are three read modes. The first returns the low half in one slot. The second returns the low half and then the high half in two consecutive slots, both from the same snapshot. The third returns the high half alone in one slot. The first scan of an acquisition, marked by a scan-start pulse with the first-scan flag set, clears the total.

Top module: `tot_top`

## Requirements
- R1: Each rising edge of `countIn` adds one to the total. With `mapMode` = 0 the total never goes down, except when it is cleared.
- R2: A cycle with `scanStart` and `firstScan` both high sets the total to zero. A snapshot taken in that same cycle captures zero.
- R3: With `latchOnMap` = 0, a `scanStart` pulse takes a snapshot of the total as it stood in that cycle, and `wordValid` is high in the next cycle.
- R4: With `latchOnMap` = 1, only a rising edge of the mapped source takes a snapshot. A `scanStart` pulse then produces no output word.
- R5: `mapSel` values 0 to 7 pick debounced channel `srcBank[mapSel]`. Values 8 to 15 pick detection flag `srcBank[mapSel]`. Only the selected bit has any effect.
- R6: With `mapMode` = 1 (gate), a main-input edge is counted only while the mapped source is high.
- R7: With `mapMode` = 2 (increment), each rising edge of the mapped source adds one, on top of any main-input edge in the same cycle.
- R8: With `mapMode` = 3 (decrement), each rising edge of the mapped source subtracts one. If it coincides with a main-input edge, the two cancel. The total wraps modulo 2^32, so a decrement from zero gives 0xFFFFFFFF.
- R9: With `readMode` 0 or 3, a snapshot yields one word holding total bits 15:0, valid in the cycle after the snapshot.
- R10: With `readMode` = 1, the cycle after the snapshot carries bits 15:0 and the following cycle carries bits 31:16 of the same snapshot. A snapshot request that arrives while the low word is on the output is dropped.
- R11: With `readMode` = 2, a snapshot yields one word holding total bits 31:16.
- R12: After reset the total is zero and `wordValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countIn | input | 1 | Main event input; rising edges are counted |
| srcBank | input | 16 | Candidate mapped sources: [7:0] debounced channels, [15:8] detection flags |
| mapSel | input | 4 | Index of the mapped source within `srcBank` |
| scanStart | input | 1 | One-cycle scan start pulse |
| firstScan | input | 1 | Marks the scan start as the first of an acquisition |
| mapMode | input | 2 | 0 none, 1 gate, 2 increment, 3 decrement |
| latchOnMap | input | 1 | 1: snapshot on mapped rising edge; 0: snapshot on scan start |
| readMode | input | 2 | 0/3 low word, 1 low then high word, 2 high word only |
| wordOut | output | 16 | Sample word |
| wordValid | output | 1 | High in each cycle that carries a sample word |

## Verification
The bench targets these cases:
- A main edge meeting a mapped decrement in the same cycle. A design that handles this wrongly drifts the total by one.
- A decrement from zero. A design that saturates, or that keeps a count narrower than 32 bits, returns the wrong high word in two-word readout.
- Two scan starts in back-to-back cycles in two-word mode. A design that accepts the second one splices halves from two different snapshots.
- The first-scan cycle. A design that clears only after latching shows a stale total.

Gating with the source low, together with scan-start pulses sent while latching is mapped, shows whether the design leaks counts or emits stray words.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic [1:0] {MAP_OFF, MAP_GATE, MAP_INC, MAP_DEC} mapMode_e;
  typedef enum logic [1:0] {RD_LOW, RD_PAIR, RD_HIGH, RD_LOW_ALT} readMode_e;
  typedef enum logic [1:0] {OS_NONE, OS_LOW, OS_HIGH, OS_PAIR_LO} outSel_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic       clr;
    logic [1:0] upCnt;
    logic       dn;
    logic       snap;
    outSel_e    outSel;
  } tot_strobe_t;
endpackage

// File: rtl/tot_ctrl.sv
module tot_ctrl
  import tot_pkg::*;
#(
  parameter int SRC_N = 16,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countIn,
  input  logic [SRC_N-1:0] srcBank,
  input  logic [SEL_W-1:0] mapSel,
  input  logic             scanStart,
  input  logic             firstScan,
  input  logic [1:0]       mapMode,
  input  logic             latchOnMap,
  input  logic [1:0]       readMode,
  output tot_strobe_t      strb
);
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_HIGH} phase_e;

  phase_e    phase, phaseNext;
  logic      countInQ, selQ;
  logic      selBit, mainEdge, mapEdge, mainOk, latchEv, pairLowSlot;
  mapMode_e  mm;
  readMode_e rm;

  assign selBit   = srcBank[mapSel];
  assign mainEdge = countIn & ~countInQ;
  assign mapEdge  = selBit & ~selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countInQ <= 1'b0;
      selQ     <= 1'b0;
      phase    <= PH_IDLE;
    end else begin
      countInQ <= countIn;
      selQ     <= selBit;
      phase    <= phaseNext;
    end
  end

  always_comb begin
    mm          = mapMode_e'(mapMode);
    rm          = readMode_e'(readMode);
    mainOk      = mainEdge & ((mm != MAP_GATE) | selBit);
    latchEv     = latchOnMap ? mapEdge : scanStart;
    pairLowSlot = (phase == PH_FIRST) && (rm == RD_PAIR);

    strb.clr    = scanStart & firstScan;
    strb.upCnt  = {1'b0, mainOk} + {1'b0, (mm == MAP_INC) & mapEdge};
    strb.dn     = (mm == MAP_DEC) & mapEdge;
    strb.snap   = latchEv & ~pairLowSlot;

    unique case (phase)
      PH_FIRST: begin
        if (rm == RD_PAIR)      strb.outSel = OS_PAIR_LO;
        else if (rm == RD_HIGH) strb.outSel = OS_HIGH;
        else                    strb.outSel = OS_LOW;
      end
      PH_HIGH: strb.outSel = OS_HIGH;
      default: strb.outSel = OS_NONE;
    endcase

    if (pairLowSlot)    phaseNext = PH_HIGH;
    else if (strb.snap) phaseNext = PH_FIRST;
    else                phaseNext = PH_IDLE;
  end

  // Second slot of a pair always carries the high word.
  p_pair_high_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FIRST && rm == RD_PAIR) |=> strb.outSel == OS_HIGH);

  // Gate mode with the source low lets nothing into the count.
  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mm == MAP_GATE && !selBit) |-> strb.upCnt == 2'd0);
endmodule

// File: rtl/tot_dp.sv
module tot_dp
  import tot_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tot_strobe_t       strb,
  output logic [CNT_W-1:0]  countQ,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [CNT_W-1:0] snapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      snapQ  <= '0;
    end else begin
      if (strb.clr) countQ <= '0;
      else          countQ <= countQ + CNT_W'(strb.upCnt) - CNT_W'(strb.dn);
      if (strb.snap) snapQ <= strb.clr ? '0 : countQ;
    end
  end

  always_comb begin
    wordValid = (strb.outSel != OS_NONE);
    if (strb.outSel == OS_HIGH) wordOut = snapQ[CNT_W-1:WORD_W];
    else                        wordOut = snapQ[WORD_W-1:0];
  end

  // Without a decrement the total moves up by at most two.
  p_up_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && !strb.dn) |=> (countQ - $past(countQ)) <= CNT_W'(2));

  // Snapshot must not change between the two words of a pair.
  p_pair_snap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.outSel == OS_PAIR_LO) |=> $stable(snapQ));
endmodule

// File: rtl/tot_top.sv
module tot_top
  import tot_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SRC_N  = 16,
  localparam int CNT_W = 2 * WORD_W,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              countIn,
  input  logic [SRC_N-1:0]  srcBank,
  input  logic [SEL_W-1:0]  mapSel,
  input  logic              scanStart,
  input  logic              firstScan,
  input  logic [1:0]        mapMode,
  input  logic              latchOnMap,
  input  logic [1:0]        readMode,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  tot_strobe_t      strb;
  logic [CNT_W-1:0] cntQ;

  tot_ctrl #(.SRC_N(SRC_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .countIn(countIn), .srcBank(srcBank),
    .mapSel(mapSel), .scanStart(scanStart), .firstScan(firstScan),
    .mapMode(mapMode), .latchOnMap(latchOnMap), .readMode(readMode),
    .strb(strb)
  );

  tot_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .countQ(cntQ),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  p_first_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scanStart && firstScan) |=> cntQ == '0);

  p_scan_latch_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (scanStart && !latchOnMap) |=> wordValid);
endmodule

// File: tb/tot_top_tb_top.sv
`timescale 1ns/1ps
module tot_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countIn = 1'b0;
  logic [15:0] srcBank = '0;
  logic [3:0]  mapSel = '0;
  logic        scanStart = 1'b0, firstScan = 1'b0;
  logic [1:0]  mapMode = '0;
  logic        latchOnMap = 1'b0;
  logic [1:0]  readMode = '0;
  logic [15:0] wordOut;
  logic        wordValid;

  int    errors = 0, checks = 0;
  string curTag = "R12";

  // reference model state
  logic [31:0] mCount = '0, mSnap = '0;
  int          mPhase = 0;
  logic        mPrevIn = 1'b0, mPrevSel = 1'b0;

  always #2.5 clk = ~clk;

  tot_top dut_i (
    .clk(clk), .rstN(rstN), .countIn(countIn), .srcBank(srcBank),
    .mapSel(mapSel), .scanStart(scanStart), .firstScan(firstScan),
    .mapMode(mapMode), .latchOnMap(latchOnMap), .readMode(readMode),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic sel, mainE, mapE, clr, mainOk, latchEv, pairLo, doSnap;
    logic [31:0] nxt;
    if (!rstN) begin
      mCount = '0; mSnap = '0; mPhase = 0; mPrevIn = 0; mPrevSel = 0;
      return;
    end
    sel    = srcBank[mapSel];
    mainE  = countIn && !mPrevIn;
    mapE   = sel && !mPrevSel;
    clr    = scanStart && firstScan;
    mainOk = mainE && (mapMode != 2'd1 || sel);
    nxt    = mCount + 32'(mainOk) + 32'(mapMode == 2'd2 && mapE)
                    - 32'(mapMode == 2'd3 && mapE);
    latchEv = latchOnMap ? mapE : scanStart;
    pairLo  = (mPhase == 1) && (readMode == 2'd1);
    doSnap  = latchEv && !pairLo;
    if (doSnap) mSnap = clr ? '0 : mCount;
    mPhase  = pairLo ? 2 : (doSnap ? 1 : 0);
    mCount  = clr ? '0 : nxt;
    mPrevIn = countIn;
    mPrevSel = sel;
  endtask

  task automatic compareOut();
    logic [15:0] expW;
    check({curTag, " valid"}, 32'(wordValid), 32'(mPhase != 0));
    if (mPhase != 0) begin
      if (mPhase == 2 || (mPhase == 1 && readMode == 2'd2)) expW = mSnap[31:16];
      else expW = mSnap[15:0];
      check({curTag, " word"}, 32'(wordOut), 32'(expW));
    end
  endtask

  task automatic cycle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      if (rstN) compareOut();
    end
  endtask

  task automatic pulseIn(int n);
    for (int i = 0; i < n; i++) begin
      countIn = 1'b1; cycle();
      countIn = 1'b0; cycle();
    end
  endtask

  task automatic scanLatch();
    scanStart = 1'b1; cycle(); scanStart = 1'b0;
  endtask

  task automatic expectWord(string tag, logic [15:0] val);
    check({tag, " literal valid"}, 32'(wordValid), 32'd1);
    check({tag, " literal word"}, 32'(wordOut), 32'(val));
  endtask

  task automatic firstScanClear();
    scanStart = 1'b1; firstScan = 1'b1; cycle();
    scanStart = 1'b0; firstScan = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); cycle(3);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R12"; check("R12 reset valid", 32'(wordValid), 32'd0);

    // R2: first scan clears and latches zero
    curTag = "R2"; pulseIn(3); firstScanClear(); expectWord("R2", 16'h0000);
    cycle(2);

    // R1 R9 R3: five main edges, latched by scan start
    curTag = "R1"; pulseIn(5);
    curTag = "R9"; scanLatch(); expectWord("R9 R3", 16'd5); cycle();
    readMode = 2'd3; scanLatch(); expectWord("R9 alt", 16'd5); cycle();
    readMode = 2'd0;

    // R4 R5: latch on mapped flag 9, scan start ignored
    curTag = "R4"; latchOnMap = 1'b1; mapSel = 4'd9; cycle();
    scanLatch(); check("R4 scan ignored", 32'(wordValid), 32'd0);
    srcBank[4] = 1'b1; cycle(); check("R5 unselected", 32'(wordValid), 32'd0);
    pulseIn(2);
    curTag = "R5"; srcBank[9] = 1'b1; cycle(); expectWord("R5 R4", 16'd7);
    srcBank[9] = 1'b0; mapSel = 4'd2; cycle();
    srcBank[2] = 1'b1; cycle(); expectWord("R5 ch2", 16'd7);
    srcBank = '0; latchOnMap = 1'b0; cycle();

    // R6 gate
    curTag = "R6"; mapMode = 2'd1; mapSel = 4'd3; pulseIn(3);
    srcBank[3] = 1'b1; pulseIn(2); scanLatch(); expectWord("R6", 16'd9);
    srcBank = '0; cycle();

    // R7 increment: mapped edge together with main edge adds two
    curTag = "R7"; mapMode = 2'd2; mapSel = 4'd12;
    countIn = 1'b1; srcBank[12] = 1'b1; cycle();
    countIn = 1'b0; srcBank[12] = 1'b0; cycle();
    scanLatch(); expectWord("R7", 16'd11); cycle();

    // R8 decrement: coincident edges cancel, then wrap below zero
    curTag = "R8"; mapMode = 2'd3;
    countIn = 1'b1; srcBank[12] = 1'b1; cycle();
    countIn = 1'b0; srcBank[12] = 1'b0; cycle();
    scanLatch(); expectWord("R8 cancel", 16'd11); cycle();
    firstScanClear(); cycle();
    srcBank[12] = 1'b1; cycle(); srcBank[12] = 1'b0; cycle();

    // R10 pair readout of 0xFFFFFFFF
    curTag = "R10"; readMode = 2'd1; mapMode = 2'd0;
    scanLatch(); expectWord("R10 R8 low", 16'hFFFF);
    cycle(); expectWord("R10 R8 high", 16'hFFFF); cycle();
    pulseIn(2); // wraps to 1
    // back-to-back scan starts: second one dropped
    scanStart = 1'b1; cycle(); expectWord("R10 low", 16'd1);
    countIn = 1'b1; cycle(); countIn = 1'b0; scanStart = 1'b0;
    expectWord("R10 high", 16'd0);
    cycle(); check("R10 dropped", 32'(wordValid), 32'd0);

    // R11 high word only
    curTag = "R11"; readMode = 2'd2; srcBank[12] = 1'b1; mapMode = 2'd3; cycle();
    srcBank = '0; mapMode = 2'd0; cycle();
    scanLatch(); expectWord("R11", 16'd0);
    cycle();

    // constrained random phase
    for (int blk = 0; blk < 20; blk++) begin
      curTag = (blk % 2 == 0) ? "R1" : "R10";
      readMode   = 2'($urandom_range(3));
      mapMode    = 2'($urandom_range(3));
      latchOnMap = 1'($urandom_range(1));
      mapSel     = 4'($urandom_range(15));
      for (int c = 0; c < 200; c++) begin
        countIn   = ($urandom_range(99) < 45);
        srcBank   = srcBank ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
        scanStart = ($urandom_range(99) < 12);
        firstScan = scanStart && ($urandom_range(99) < 4);
        cycle();
      end
      countIn = 1'b0; scanStart = 1'b0; firstScan = 1'b0;
      cycle(3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule